// File: doc/BRIEF.md
# Single-Pass Display Packet Splitter and Pixel Packer

This block sits on the receive side of a display serial link, directly after the PHY. It takes 32-bit words and handles every packet in one pass. The first word of a packet is the header and leaves on its own output. The payload bytes that follow are packed into pixels of a size chosen at run time. The two bytes after the payload leave as the checksum field. No stage first re-aligns the packet to the PHY width and then converts it to pixels.

Every pixel size is described as a number of whole base words plus a remainder smaller than one word. The base width equals the input word width, so the header is simply one base. Each pixel is built from whole input words plus a carried leftover of fewer than one pixel of bits. Leftover bits roll over into the next pixel. A packet whose payload does not fill a whole number of pixels is flagged, and its tail bits are dropped.

Top module: `dsi_pixel_aligner`

## Requirements
- R1: A word accepted with `in_sop` high is the header. It appears on `hdr_data` with `hdr_valid` high for one cycle, one cycle after it is accepted. Header bits 23:8 give the payload length in bytes.
- R2: Payload bytes form a bit stream. Within each word, byte k sits at bits 8k+7:8k, and byte 0 comes first. Each bit of a byte keeps its weight. Pixel n holds stream bits nP to nP+P-1, with the earliest bit at bit 0. `pix_fmt` carries the format latched at the header.
- R3: `pix_sel` is sampled with the header and selects the pixel size P, written as bases + remainder: 0 = 1+0 (32 bits), 1 = 1+4 (36), 2 = 1+16 (48), 3 = 2+0 (64). The pixel occupies the low P bits of `pix_data`, and the upper bits are zero.
- R4: The two bytes that follow the payload form the checksum, with the first byte in bits 7:0. They may share a word with payload, or be split across two words. `csum_valid` pulses one cycle after the word holding the second byte is accepted. Bytes after the checksum in that word are ignored.
- R5: A header with payload length 0 makes the next word the checksum word. No pixel and no error follow.
- R6: If the payload length in bits is not a multiple of P, `pkt_err` pulses one cycle after the last payload word is accepted. The partial pixel is discarded and is not emitted.
- R7: While `pix_valid` is high and `pix_ready` is low, `in_ready` is low and `pix_data` holds steady. No payload bit is lost or duplicated under any stall pattern.
- R8: An active-low synchronous reset clears the leftover bits, the byte counter, the packet state and all valid outputs. A packet started after reset is handled correctly, even when the reset cut a packet short.
- R9: A word accepted without `in_sop` between packets is discarded and produces no header, pixel, checksum or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_sel | input | 2 | Pixel format, sampled with the header word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_sop | input | 1 | Word is the first of a packet |
| in_data | input | 32 | Input word from the PHY |
| hdr_valid | output | 1 | Header pulse |
| hdr_data | output | 32 | Captured header word |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Pixel consumer ready |
| pix_data | output | 64 | Pixel, right-aligned |
| pix_fmt | output | 2 | Format of the pixel on `pix_data` |
| csum_valid | output | 1 | Checksum pulse |
| csum_data | output | 16 | Checksum field |
| pkt_err | output | 1 | Payload ended with a partial pixel |

## Verification
The bench builds the block with its defaults: 32-bit words and a 64-bit pixel ceiling. All four formats are therefore reachable, including the two-base 64-bit pixel that needs a 95-bit carry register. Payload lengths are chosen so that the checksum lands at a word start, in the middle of a word, and split across two words. Lengths that leave leftover bits are also covered. The stalled-consumer runs exercise the path where a pixel waits while the next word is held off.

// File: rtl/dsi_pix_pkg.sv
// Package: shared packet state type and the pixel-format description
// (whole bases plus remainder bits). Assumes format codes 0..3.
package dsi_pix_pkg;

    typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_CSUM} pkt_st_t;

    // Number of whole input words in one pixel of the given format.
    function automatic int fmt_bases(logic [1:0] f);
        return (f == 2'd3) ? 2 : 1;
    endfunction

    // Bits beyond the whole bases for the given format.
    function automatic int fmt_rem(logic [1:0] f);
        case (f)
            2'd1:    return 4;
            2'd2:    return 16;
            default: return 0;
        endcase
    endfunction

    // Pixel size in bits for a base width w.
    function automatic int pix_bits(logic [1:0] f, int w);
        return fmt_bases(f) * w + fmt_rem(f);
    endfunction

endpackage

// File: rtl/dsi_pkt_tracker.sv
// Tracker: sorts each accepted word as header, payload or checksum by
// counting bytes against the header length. It tells the packer how many
// payload bytes a word carries and whether the payload ends in it.
// Assumes that bytes within a word go in ascending order from bit 0.
module dsi_pkt_tracker
    import dsi_pix_pkg::*;
#(
    parameter int W       = 32,
    parameter int LEN_LSB = 8,
    parameter int LEN_W   = 16,
    localparam int BPW    = W / 8,
    localparam int NB_W   = $clog2(BPW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            sop,
    input  logic [W-1:0]    data,
    output logic            hdr_now,
    output logic            pay_en,
    output logic [NB_W-1:0] pay_bytes,
    output logic            pay_last,
    output logic            hdr_valid,
    output logic [W-1:0]    hdr_data,
    output logic            csum_valid,
    output logic [15:0]     csum_data
);

    pkt_st_t          state_q, state_d;
    logic [LEN_W-1:0] left_q, left_d;
    logic             got_q, got_d;
    logic [7:0]       lo_q, lo_d;
    logic             cs_en, cs_done;
    logic [15:0]      cs_val;
    logic [NB_W-1:0]  avail;
    logic [W-1:0]     shifted;

    // Classify the current word and count its payload bytes.
    always_comb begin
        hdr_now   = fire && sop;
        pay_en    = fire && !sop && state_q == ST_PAY;
        pay_bytes = '0;
        if (pay_en)
            pay_bytes = (left_q >= LEN_W'(BPW)) ? NB_W'(BPW) : left_q[NB_W-1:0];
        pay_last  = pay_en && left_q <= LEN_W'(BPW);
        cs_en     = fire && !sop && (state_q == ST_CSUM || pay_last);
        avail     = NB_W'(BPW) - pay_bytes;
        shifted   = data >> {pay_bytes, 3'b000};
    end

    // Collect checksum bytes, which may span two words.
    always_comb begin
        cs_done = 1'b0;
        cs_val  = '0;
        got_d   = got_q;
        lo_d    = lo_q;
        if (cs_en) begin
            if (got_q) begin
                cs_done = 1'b1;
                cs_val  = {shifted[7:0], lo_q};
            end else if (avail >= NB_W'(2)) begin
                cs_done = 1'b1;
                cs_val  = shifted[15:0];
            end else if (avail == NB_W'(1)) begin
                got_d = 1'b1;
                lo_d  = shifted[7:0];
            end
        end
    end

    // Next packet state and remaining payload byte count.
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (hdr_now) begin
            left_d  = data[LEN_LSB +: LEN_W];
            state_d = (data[LEN_LSB +: LEN_W] == '0) ? ST_CSUM : ST_PAY;
        end else if (pay_en) begin
            left_d = left_q - LEN_W'(pay_bytes);
            if (pay_last) state_d = cs_done ? ST_HDR : ST_CSUM;
        end else if (cs_en && cs_done) begin
            state_d = ST_HDR;
        end
    end

    // State registers and the registered header/checksum outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_HDR;
            left_q     <= '0;
            got_q      <= 1'b0;
            lo_q       <= '0;
            hdr_valid  <= 1'b0;
            hdr_data   <= '0;
            csum_valid <= 1'b0;
            csum_data  <= '0;
        end else begin
            state_q    <= state_d;
            left_q     <= left_d;
            got_q      <= hdr_now ? 1'b0 : (cs_done ? 1'b0 : got_d);
            lo_q       <= lo_d;
            hdr_valid  <= hdr_now;
            csum_valid <= cs_done;
            if (hdr_now) hdr_data  <= data;
            if (cs_done) csum_data <= cs_val;
        end
    end

    // R4: a checksum completes only from a payload or checksum phase.
    p_csum_after_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        csum_valid |-> $past(state_q) != ST_HDR);

endmodule

// File: rtl/dsi_bit_packer.sv
// Packer: appends the payload bytes of each word to a leftover register
// and emits one pixel whenever enough bits are present. It clears the
// leftover at the header and at the end of the payload.
// Assumes that P >= W, so each word yields at most one pixel.
module dsi_bit_packer
    import dsi_pix_pkg::*;
#(
    parameter int W         = 32,
    parameter int PIX_MAX_W = 64,
    localparam int BPW      = W / 8,
    localparam int NB_W     = $clog2(BPW + 1),
    localparam int ACC_W    = PIX_MAX_W + W - 1,
    localparam int CNT_W    = $clog2(ACC_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           fmt,
    input  logic                 start,
    input  logic                 word_en,
    input  logic [W-1:0]         word,
    input  logic [NB_W-1:0]      nbytes,
    input  logic                 last,
    input  logic                 pix_ready,
    output logic                 can_take,
    output logic                 pix_valid,
    output logic [PIX_MAX_W-1:0] pix_data,
    output logic [1:0]           pix_fmt,
    output logic                 pkt_err
);

    logic [ACC_W-1:0]     acc_q, merged, after_acc;
    logic [CNT_W-1:0]     cnt_q, total, after_cnt, pbits;
    logic [W-1:0]         masked;
    logic [PIX_MAX_W-1:0] low_mask;
    logic                 emit;

    // Keep only the payload bytes of the word.
    always_comb begin
        for (int b = 0; b < BPW; b++)
            masked[b*8 +: 8] = (b < int'(nbytes)) ? word[b*8 +: 8] : 8'h00;
    end

    // Merge the word above the leftover bits and split off one pixel.
    always_comb begin
        pbits     = CNT_W'(pix_bits(fmt, W));
        merged    = acc_q | (ACC_W'(masked) << cnt_q);
        total     = cnt_q + CNT_W'({nbytes, 3'b000});
        emit      = word_en && total >= pbits;
        after_cnt = emit ? total - pbits : total;
        after_acc = emit ? merged >> pbits : merged;
        low_mask  = ~({PIX_MAX_W{1'b1}} << pbits);
        can_take  = !pix_valid || pix_ready;
    end

    // Leftover register, output pixel slot and end-of-payload error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            pix_valid <= 1'b0;
            pix_data  <= '0;
            pix_fmt   <= '0;
            pkt_err   <= 1'b0;
        end else begin
            pkt_err <= word_en && last && after_cnt != '0;
            if (start || (word_en && last)) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (word_en) begin
                acc_q <= after_acc;
                cnt_q <= after_cnt;
            end
            if (emit) begin
                pix_valid <= 1'b1;
                pix_data  <= merged[PIX_MAX_W-1:0] & low_mask;
                pix_fmt   <= fmt;
            end else if (pix_ready) begin
                pix_valid <= 1'b0;
            end
        end
    end

    // R7: a held pixel does not change until it is taken.
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_fmt));

    // R3: the leftover never reaches a full pixel between words.
    p_left_below_pix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < pbits);

    // R3: bits above the pixel size stay zero.
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_data >> pix_bits(pix_fmt, W)) == '0);

endmodule

// File: rtl/dsi_pixel_aligner.sv
// Top: joins the tracker and the packer. A word is taken only while the
// pixel slot is free or draining. The format is latched with the header
// so that it stays fixed for the whole packet.
module dsi_pixel_aligner
    import dsi_pix_pkg::*;
#(
    parameter int W         = 32,
    parameter int PIX_MAX_W = 64,
    localparam int NB_W     = $clog2(W / 8 + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           pix_sel,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sop,
    input  logic [W-1:0]         in_data,
    output logic                 hdr_valid,
    output logic [W-1:0]         hdr_data,
    output logic                 pix_valid,
    input  logic                 pix_ready,
    output logic [PIX_MAX_W-1:0] pix_data,
    output logic [1:0]           pix_fmt,
    output logic                 csum_valid,
    output logic [15:0]          csum_data,
    output logic                 pkt_err
);

    logic            fire, hdr_now, pay_en, pay_last;
    logic [NB_W-1:0] pay_bytes;
    logic [1:0]      fmt_q;

    assign fire = in_valid && in_ready;

    // Hold the pixel format for the packet that has just started.
    always_ff @(posedge clk) begin
        if (!rst_n)       fmt_q <= '0;
        else if (hdr_now) fmt_q <= pix_sel;
    end

    dsi_pkt_tracker #(.W(W)) u_track (
        .clk(clk), .rst_n(rst_n), .fire(fire), .sop(in_sop), .data(in_data),
        .hdr_now(hdr_now), .pay_en(pay_en), .pay_bytes(pay_bytes),
        .pay_last(pay_last), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
        .csum_valid(csum_valid), .csum_data(csum_data)
    );

    dsi_bit_packer #(.W(W), .PIX_MAX_W(PIX_MAX_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .fmt(hdr_now ? pix_sel : fmt_q),
        .start(hdr_now), .word_en(pay_en), .word(in_data),
        .nbytes(pay_bytes), .last(pay_last), .pix_ready(pix_ready),
        .can_take(in_ready), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_fmt(pix_fmt), .pkt_err(pkt_err)
    );

    // R6: an end-of-payload error never coincides with a header pulse.
    p_err_not_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> !hdr_valid);

endmodule

// File: tb/tb_dsi_pixel_aligner.sv
module tb_dsi_pixel_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pix_sel = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0, pix_ready = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_ready, hdr_valid, pix_valid, csum_valid, pkt_err;
    logic [31:0] hdr_data;
    logic [63:0] pix_data;
    logic [1:0]  pix_fmt;
    logic [15:0] csum_data;

    int checks = 0, errors = 0, cyc = 0;
    bit stall_en = 0, done = 0;
    logic [65:0] pix_q[$];
    int hdr_cnt, cs_cnt, err_cnt;
    logic [31:0] hdr_seen;
    logic [15:0] cs_seen;

    always #10 clk = ~clk;

    dsi_pixel_aligner dut (
        .clk(clk), .rst_n(rst_n), .pix_sel(pix_sel), .in_valid(in_valid),
        .in_ready(in_ready), .in_sop(in_sop), .in_data(in_data),
        .hdr_valid(hdr_valid), .hdr_data(hdr_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_data(pix_data), .pix_fmt(pix_fmt),
        .csum_valid(csum_valid), .csum_data(csum_data), .pkt_err(pkt_err)
    );

    // Drive consumer readiness and record every output event at mid-cycle.
    always @(negedge clk) begin
        cyc++;
        pix_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
        if (pix_valid && pix_ready) pix_q.push_back({pix_fmt, pix_data});
        if (rst_n && hdr_valid)  begin hdr_cnt++; hdr_seen = hdr_data; end
        if (rst_n && csum_valid) begin cs_cnt++;  cs_seen  = csum_data; end
        if (rst_n && pkt_err)    err_cnt++;
    end

    task automatic check(bit ok, string req, logic [65:0] act, logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(logic [31:0] d, bit sop);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = sop;
        forever begin
            #2;
            if (in_ready) begin @(posedge clk); break; end
            @(negedge clk);
        end
        #1 in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic clear_obs();
        pix_q.delete();
        hdr_cnt = 0; cs_cnt = 0; err_cnt = 0;
    endtask

    // One packet: header, payload and checksum; then compare against the model.
    task automatic run_packet(logic [1:0] fmt, int len, bit stall);
        logic [7:0]   by[0:63];
        logic [511:0] stream;
        logic [63:0]  exp_pix, mask;
        logic [31:0]  hdr, w;
        int p, npix, nw;
        bit bad;
        clear_obs();
        pix_sel = fmt; stall_en = stall;
        p = (fmt == 2'd3) ? 64 : (fmt == 2'd2) ? 48 : (fmt == 2'd1) ? 36 : 32;
        stream = '0;
        for (int i = 0; i < len; i++) begin
            by[i] = 8'(i * 37 + fmt * 11 + len + 1);
            stream[i*8 +: 8] = by[i];
        end
        by[len] = 8'hA5 ^ 8'(len); by[len+1] = 8'h3C + 8'(fmt);
        for (int i = len + 2; i < 64; i++) by[i] = 8'hEE;
        hdr = {8'h5A, 16'(len), 8'h29};
        send_word(hdr, 1'b1);
        nw = (len + 2 + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            w = {by[4*k+3], by[4*k+2], by[4*k+1], by[4*k]};
            send_word(w, 1'b0);
        end
        repeat (12) @(negedge clk);
        stall_en = 0;
        repeat (6) @(negedge clk);
        npix = (len * 8) / p;
        check(hdr_cnt == 1 && hdr_seen == hdr, "R1 header", 66'(hdr_seen), 66'(hdr));
        check(pix_q.size() == npix, "R3 pixel count", 66'(pix_q.size()), 66'(npix));
        mask = (p == 64) ? '1 : ((64'd1 << p) - 64'd1);
        bad = 0;
        for (int n = 0; n < npix && n < pix_q.size(); n++) begin
            exp_pix = 64'(stream >> (n * p)) & mask;
            if (pix_q[n] != {fmt, exp_pix}) begin
                bad = 1;
                check(0, stall ? "R7 pixel under stall" : "R2 pixel value", pix_q[n], {fmt, exp_pix});
            end
        end
        if (!bad) check(1, "R2 pixel value", 0, 0);
        check(cs_cnt == 1 && cs_seen == {by[len+1], by[len]}, len == 0 ? "R5 checksum" : "R4 checksum",
              66'(cs_seen), 66'({by[len+1], by[len]}));
        check(err_cnt == (((len * 8) % p != 0) ? 1 : 0), "R6 error flag",
              66'(err_cnt), 66'(((len * 8) % p != 0) ? 1 : 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(!pix_valid && !hdr_valid && !csum_valid && !pkt_err && in_ready,
              "R8 reset state", {pix_valid, hdr_valid, csum_valid, pkt_err, in_ready}, 66'h1);
        run_packet(2'd0, 8, 0);    // two 32-bit pixels, checksum in its own word
        run_packet(2'd1, 9, 1);    // 36-bit pixels across words, stalled
        run_packet(2'd2, 12, 0);   // 48-bit pixels
        run_packet(2'd3, 16, 1);   // two-base pixels, stalled
        run_packet(2'd2, 10, 0);   // partial 48-bit pixel -> R6
        run_packet(2'd0, 3, 0);    // checksum split across words, R6
        run_packet(2'd1, 0, 0);    // R5 zero-length payload
        // R9: a stray word between packets leaves no trace
        clear_obs();
        send_word(32'hDEADBEEF, 1'b0);
        repeat (4) @(negedge clk);
        check(hdr_cnt == 0 && cs_cnt == 0 && err_cnt == 0 && pix_q.size() == 0,
              "R9 stray word ignored", 66'(hdr_cnt + cs_cnt + err_cnt + pix_q.size()), 0);
        // R8: reset in mid-packet, then a clean packet
        clear_obs(); pix_sel = 2'd0;
        send_word({8'h00, 16'd16, 8'h29}, 1'b1);
        send_word(32'h11111111, 1'b0);
        send_word(32'h22222222, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        #2;
        check(!pix_valid && in_ready, "R8 mid-packet reset", {pix_valid, in_ready}, 66'h1);
        run_packet(2'd1, 9, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule